// File: doc/BRIEF.md
# Controller Mode and Soft-Reset Manager

This block is the control register and mode sequencer that sits in front of a bus protocol controller. Software programs a small control word with a disable bit, a freeze-enable bit and a halt bit. From these bits and an external debug request the block derives one of three operating modes: running, frozen or disabled. It drives the clock enables for the protocol engine and the buffer manager, a transmit/receive permit, and a not-ready status bit that software can read.

The block also runs a soft reset. A CPU write of 1 to the reset bit, or a pulse on the global soft-reset input, raises a request. The request crosses into the protocol clock domain through a level synchronizer, and the acknowledge returns the same way. When the acknowledge arrives, the block clears a chosen set of state registers in one step and the reset bit drops. Software polls the bit to learn that the reset is complete. The block keeps the registers that a soft reset touches: timer, error counter, error status, interrupt mask and interrupt flags. It also keeps the bus configuration and acceptance mask registers, which a soft reset leaves alone. The error counter takes CPU writes only while the module is frozen.

Top module: `mcm_top`

## Requirements
- R1: With the disable bit set (control bit 0), the mode output reads 2, and the engine and buffer clock enables and the transmit/receive permit are all 0 from the second clock edge after the write. With the disable bit clear, both clock enables are 1.
- R2: Freeze is entered (mode output 1, permit 0, clock enables 1) when the disable bit is clear, the freeze-enable bit (control bit 1) is set, and either the halt bit (control bit 2) is set or the debug request input is high.
- R3: With the freeze-enable bit clear, or with halt and debug both low, the module runs (mode output 0, permit 1). When the disable bit is set, disable wins over freeze.
- R4: The not-ready bit (control bit 3, read-only) reads 1 in the disabled or frozen mode and reads 0 while running.
- R5: The error counter register (address 2) accepts a CPU write only while frozen. In the running or disabled mode a write leaves it unchanged.
- R6: The soft-reset bit (control bit 4) becomes 1 on a CPU write of 1 to it or on a high global soft-reset input. It stays 1 until the handshake completes and then clears itself. A write of 0 to it has no effect.
- R7: Completing a soft reset clears freeze-enable, halt, the timer (address 1), the error counter, the error status (address 3), the interrupt mask (address 4) and the interrupt flags (address 5). It keeps the disable bit, the bus configuration (address 6) and the acceptance mask (address 7).
- R8: The request holds until the synchronized acknowledge is seen. The protocol-domain reset output is high during the handshake and returns low once the request is withdrawn.
- R9: Control bits 5 and up read 0, and writes to them are ignored. The timer is read-only.
- R10: The timer advances by one on each clock while the module runs and holds its value while frozen or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Host-side active-low reset |
| pclk | input | 1 | Protocol-domain clock |
| prst_n | input | 1 | Protocol-domain active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| dbg_req | input | 1 | External debug request, enters freeze when enabled |
| glob_srst | input | 1 | Global soft-reset request |
| mode_o | output | 2 | Current mode: 0 run, 1 frozen, 2 disabled |
| eng_clk_en | output | 1 | Protocol engine clock enable |
| buf_clk_en | output | 1 | Buffer manager clock enable |
| txrx_en | output | 1 | Frame reception and transmission permitted |
| p_srst | output | 1 | Soft-reset level in the protocol clock domain |

## Verification
The bench goes after the priority between disable and freeze. It sets all three control bits together, and a design that let freeze win would report mode 1 and keep the clocks on. It writes the error counter in each of the three modes, so a design with the write gate on the wrong mode either loses the frozen write or accepts a write while running. A soft reset is issued while the module is disabled, and the bench then reads every register. This catches a design that also clears the disable bit, leaves the halt bit set, or wipes the bus configuration or the acceptance mask. The bench also samples the protocol-side reset both during and after the handshake, and uses the global input as a second source of the request, so a design that drops the bit before the acknowledge arrives, or never clears it, is reported.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int unsigned ADDR_W = 3;

    // control word bit positions
    localparam int unsigned CB_DIS  = 0;
    localparam int unsigned CB_FRZ  = 1;
    localparam int unsigned CB_HALT = 2;
    localparam int unsigned CB_NRDY = 3;
    localparam int unsigned CB_SRST = 4;

    typedef enum logic [1:0] {
        MODE_RUN = 2'd0,
        MODE_FRZ = 2'd1,
        MODE_DIS = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        RA_CTRL    = 3'd0,
        RA_TIMER   = 3'd1,
        RA_ERRCNT  = 3'd2,
        RA_ERRSTAT = 3'd3,
        RA_IMASK   = 3'd4,
        RA_IFLAG   = 3'd5,
        RA_BUSCFG  = 3'd6,
        RA_AMASK   = 3'd7
    } raddr_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_DROP = 2'd2
    } hs_e;

    typedef struct packed {
        logic dis;
        logic frz_en;
        logic halt;
    } ctrl_t;
endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mcm_srst_fsm.sv
module mcm_srst_fsm
    import mcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic glob_req,
    input  logic ack_s,
    output logic req_o,
    output logic busy_o,
    output logic clr_o
);
    typedef struct packed {
        hs_e  st;
        logic pend;
    } hs_state_t;

    hs_state_t s_d, s_q;
    logic      new_req;

    always_comb begin
        s_d     = s_q;
        clr_o   = 1'b0;
        new_req = cpu_req | glob_req;
        unique case (s_q.st)
            HS_IDLE: if (new_req) s_d.st = HS_REQ;
            HS_REQ: begin
                // requests arriving now merge into the one in flight
                if (ack_s) begin
                    s_d.st   = HS_DROP;
                    s_d.pend = 1'b0;
                    clr_o    = 1'b1;
                end
            end
            HS_DROP: begin
                if (new_req) s_d.pend = 1'b1;
                if (!ack_s) begin
                    s_d.st   = (s_q.pend || new_req) ? HS_REQ : HS_IDLE;
                    s_d.pend = 1'b0;
                end
            end
            default: s_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: HS_IDLE, pend: 1'b0};
        else        s_q <= s_d;
    end

    assign req_o  = (s_q.st == HS_REQ);
    assign busy_o = (s_q.st == HS_REQ) || s_q.pend;
endmodule

// File: rtl/mcm_mode.sv
module mcm_mode
    import mcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  dbg_req,
    output mode_e mode_o,
    output logic  eng_en,
    output logic  buf_en,
    output logic  txrx_en,
    output logic  nrdy
);
    mode_e mode_d, mode_q;

    always_comb begin
        if (ctrl.dis)                                mode_d = MODE_DIS;
        else if (ctrl.frz_en && (ctrl.halt || dbg_req)) mode_d = MODE_FRZ;
        else                                         mode_d = MODE_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    assign mode_o  = mode_q;
    assign eng_en  = (mode_q != MODE_DIS);
    assign buf_en  = (mode_q != MODE_DIS);
    assign txrx_en = (mode_q == MODE_RUN);
    assign nrdy    = (mode_q != MODE_RUN);
endmodule

// File: rtl/mcm_regs.sv
module mcm_regs
    import mcm_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  mode_e             mode,
    input  logic              nrdy,
    input  logic              srst_busy,
    input  logic              clr,
    output ctrl_t             ctrl_o,
    output logic              cpu_srst,
    output logic [DW-1:0]     errcnt_o,
    output logic [DW-1:0]     imask_o,
    output logic [DW-1:0]     iflag_o
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] timer;
        logic [DW-1:0] errcnt;
        logic [DW-1:0] errstat;
        logic [DW-1:0] imask;
        logic [DW-1:0] iflag;
        logic [DW-1:0] buscfg;
        logic [DW-1:0] amask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        cpu_srst = 1'b0;
        if (mode == MODE_RUN) r_d.timer = r_q.timer + 1'b1;
        if (wr_en) begin
            unique case (raddr_e'(addr))
                RA_CTRL: begin
                    r_d.ctrl.dis    = wdata[CB_DIS];
                    r_d.ctrl.frz_en = wdata[CB_FRZ];
                    r_d.ctrl.halt   = wdata[CB_HALT];
                    cpu_srst        = wdata[CB_SRST];
                end
                RA_ERRCNT:  if (mode == MODE_FRZ) r_d.errcnt = wdata;
                RA_ERRSTAT: r_d.errstat = wdata;
                RA_IMASK:   r_d.imask   = wdata;
                RA_IFLAG:   r_d.iflag   = wdata;
                RA_BUSCFG:  r_d.buscfg  = wdata;
                RA_AMASK:   r_d.amask   = wdata;
                default: ;
            endcase
        end
        // handshake completion wins over any same-cycle write
        if (clr) begin
            r_d.ctrl.frz_en = 1'b0;
            r_d.ctrl.halt   = 1'b0;
            r_d.timer       = '0;
            r_d.errcnt      = '0;
            r_d.errstat     = '0;
            r_d.imask       = '0;
            r_d.iflag       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        unique case (raddr_e'(addr))
            RA_CTRL: begin
                rdata[CB_DIS]  = r_q.ctrl.dis;
                rdata[CB_FRZ]  = r_q.ctrl.frz_en;
                rdata[CB_HALT] = r_q.ctrl.halt;
                rdata[CB_NRDY] = nrdy;
                rdata[CB_SRST] = srst_busy;
            end
            RA_TIMER:   rdata = r_q.timer;
            RA_ERRCNT:  rdata = r_q.errcnt;
            RA_ERRSTAT: rdata = r_q.errstat;
            RA_IMASK:   rdata = r_q.imask;
            RA_IFLAG:   rdata = r_q.iflag;
            RA_BUSCFG:  rdata = r_q.buscfg;
            RA_AMASK:   rdata = r_q.amask;
            default: ;
        endcase
    end

    assign ctrl_o   = r_q.ctrl;
    assign errcnt_o = r_q.errcnt;
    assign imask_o  = r_q.imask;
    assign iflag_o  = r_q.iflag;
endmodule

// File: rtl/mcm_top.sv
module mcm_top
    import mcm_pkg::*;
#(
    parameter int unsigned DW        = 16,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pclk,
    input  logic          prst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          dbg_req,
    input  logic          glob_srst,
    output logic [1:0]    mode_o,
    output logic          eng_clk_en,
    output logic          buf_clk_en,
    output logic          txrx_en,
    output logic          p_srst
);
    ctrl_t         ctrl;
    mode_e         mode;
    logic          nrdy, srst_busy, srst_clr, cpu_srst, hs_req, ack_s;
    logic          ctrl_dis, ctrl_frz, ctrl_halt;
    logic [DW-1:0] errcnt, imask, iflag;

    assign ctrl_dis  = ctrl.dis;
    assign ctrl_frz  = ctrl.frz_en;
    assign ctrl_halt = ctrl.halt;
    assign mode_o    = mode;

    mcm_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mode(mode), .nrdy(nrdy),
        .srst_busy(srst_busy), .clr(srst_clr), .ctrl_o(ctrl),
        .cpu_srst(cpu_srst), .errcnt_o(errcnt), .imask_o(imask), .iflag_o(iflag)
    );

    mcm_mode u_mode (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dbg_req(dbg_req),
        .mode_o(mode), .eng_en(eng_clk_en), .buf_en(buf_clk_en),
        .txrx_en(txrx_en), .nrdy(nrdy)
    );

    mcm_srst_fsm u_hs (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_srst), .glob_req(glob_srst),
        .ack_s(ack_s), .req_o(hs_req), .busy_o(srst_busy), .clr_o(srst_clr)
    );

    // request into the protocol domain; its synchronized level is the acknowledge
    mcm_sync #(.STAGES(SYNC_STGS)) u_req_sync (
        .clk(pclk), .rst_n(prst_n), .d(hs_req), .q(p_srst)
    );

    mcm_sync #(.STAGES(SYNC_STGS)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(p_srst), .q(ack_s)
    );
endmodule

// File: rtl/mcm_chk.sv
module mcm_chk
    import mcm_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_dis,
    input logic          ctrl_frz,
    input logic          ctrl_halt,
    input logic          dbg_req,
    input logic [1:0]    mode_o,
    input logic          eng_clk_en,
    input logic          buf_clk_en,
    input logic          txrx_en,
    input logic          nrdy,
    input logic          srst_busy,
    input logic          srst_clr,
    input logic          hs_req,
    input logic          ack_s,
    input logic [DW-1:0] errcnt,
    input logic [DW-1:0] imask,
    input logic [DW-1:0] iflag
);
    p_dis_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_dis |=> (!eng_clk_en && !buf_clk_en && mode_o == MODE_DIS));

    p_frz_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_dis && ctrl_frz && (ctrl_halt || dbg_req)) |=> (mode_o == MODE_FRZ && !txrx_en));

    p_frz_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_dis && !ctrl_frz) |=> (mode_o == MODE_RUN && txrx_en));

    p_nrdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        txrx_en |-> !nrdy);

    p_errcnt_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_FRZ && !srst_clr) |=> $stable(errcnt));

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req |-> srst_busy);

    p_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> (!ctrl_frz && !ctrl_halt && errcnt == '0 && imask == '0 && iflag == '0));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req && !ack_s) |=> hs_req);
endmodule

bind mcm_top mcm_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_dis(ctrl_dis), .ctrl_frz(ctrl_frz),
    .ctrl_halt(ctrl_halt), .dbg_req(dbg_req), .mode_o(mode_o),
    .eng_clk_en(eng_clk_en), .buf_clk_en(buf_clk_en), .txrx_en(txrx_en),
    .nrdy(nrdy), .srst_busy(srst_busy), .srst_clr(srst_clr), .hs_req(hs_req),
    .ack_s(ack_s), .errcnt(errcnt), .imask(imask), .iflag(iflag)
);

// File: tb/mcm_top_test.sv
`timescale 1ns/100ps
module mcm_top_test;
    localparam int DW = 16;

    logic          clk = 1'b0, pclk = 1'b0;
    logic          rst_n = 1'b0, prst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dbg_req = 1'b0, glob_srst = 1'b0;
    logic [1:0]    mode_o;
    logic          eng_clk_en, buf_clk_en, txrx_en, p_srst;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;
    initial begin
        #2.3;
        forever #6.5 pclk = ~pclk;
    end

    mcm_top #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .prst_n(prst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dbg_req(dbg_req), .glob_srst(glob_srst),
        .mode_o(mode_o), .eng_clk_en(eng_clk_en), .buf_clk_en(buf_clk_en),
        .txrx_en(txrx_en), .p_srst(p_srst)
    );

    // kinds: 0 register read, 1 mode, 2 {eng,buf,txrx}, 3 p_srst
    typedef struct {
        int            kind;
        logic [DW-1:0] exp;
        bit            nz;
        string         tag;
    } item_t;

    item_t sb_q[$];

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t         it;
            logic [DW-1:0] act;
            bit            ok;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {{(DW-2){1'b0}}, mode_o};
                2:       act = {{(DW-3){1'b0}}, eng_clk_en, buf_clk_en, txrx_en};
                default: act = {{(DW-1){1'b0}}, p_srst};
            endcase
            ok = it.nz ? (act != '0) : (act === it.exp);
            total++;
            if (!ok) begin
                bad++;
                if (it.nz) $display("FAIL %s: actual=%h expected=nonzero", it.tag, act);
                else       $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [2:0] a, input logic [DW-1:0] e,
                       input bit nz, input string tag);
        item_t it;
        @(posedge clk); #2;
        reg_addr = a;
        it.kind = kind; it.exp = e; it.nz = nz; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_srst_done(input string tag);
        bit cleared = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            reg_addr = 3'd0;
            #1;
            if (reg_rdata[4] == 1'b0) begin
                cleared = 1;
                break;
            end
        end
        total++;
        if (!cleared) begin
            bad++;
            $display("FAIL %s: actual=reset bit stuck expected=cleared", tag);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] tsnap;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1; prst_n = 1'b1;
        repeat (2) @(posedge clk);

        // reset state
        chk(0, 3'd0, 16'h0000, 0, "R4 reset control");
        chk(1, 3'd0, 16'd0, 0, "R3 reset mode run");
        chk(2, 3'd0, 16'h0007, 0, "R1 reset enables");

        wr(3'd4, 16'hA5A5);
        wr(3'd5, 16'h0F0F);
        wr(3'd6, 16'h1234);
        wr(3'd7, 16'hBEEF);
        wr(3'd3, 16'h0055);
        wr(3'd2, 16'h0077);
        chk(0, 3'd2, 16'h0000, 0, "R5 errcnt write ignored while running");
        wr(3'd1, 16'hFFFF);
        chk(0, 3'd1, 16'h0000, 1, "R10 timer runs");

        // reserved control bits (bit 4 left 0 to avoid a reset)
        wr(3'd0, 16'hFFE8);
        chk(0, 3'd0, 16'h0000, 0, "R9 reserved bits read 0");

        // freeze through halt
        wr(3'd0, 16'h0006);
        chk(1, 3'd0, 16'd1, 0, "R2 halt freezes");
        chk(2, 3'd0, 16'h0006, 0, "R2 frozen enables");
        chk(0, 3'd0, 16'h000E, 0, "R4 not-ready while frozen");
        wr(3'd2, 16'h0077);
        chk(0, 3'd2, 16'h0077, 0, "R5 errcnt writable while frozen");
        @(negedge clk); reg_addr = 3'd1; #1; tsnap = reg_rdata;
        repeat (5) @(posedge clk);
        chk(0, 3'd1, tsnap, 0, "R10 timer holds while frozen");

        // halt without freeze enable
        wr(3'd0, 16'h0004);
        chk(1, 3'd0, 16'd0, 0, "R3 halt alone runs");
        chk(0, 3'd0, 16'h0004, 0, "R4 not-ready clear while running");

        // debug request
        wr(3'd0, 16'h0002);
        @(negedge clk); dbg_req = 1'b1;
        repeat (2) @(posedge clk);
        chk(1, 3'd0, 16'd1, 0, "R2 debug freezes");
        @(negedge clk); dbg_req = 1'b0;
        repeat (2) @(posedge clk);
        chk(1, 3'd0, 16'd0, 0, "R3 debug release runs");

        // disable priority
        wr(3'd0, 16'h0007);
        chk(1, 3'd0, 16'd2, 0, "R3 disable beats freeze");
        chk(2, 3'd0, 16'h0000, 0, "R1 disabled enables off");
        chk(0, 3'd0, 16'h000F, 0, "R4 not-ready while disabled");
        wr(3'd2, 16'h0099);
        chk(0, 3'd2, 16'h0077, 0, "R5 errcnt write ignored while disabled");

        // CPU soft reset while disabled
        wr(3'd0, 16'h0017);
        chk(0, 3'd0, 16'h001F, 0, "R6 reset bit set");
        @(posedge clk);
        chk(3, 3'd0, 16'd1, 0, "R8 protocol reset during handshake");
        wait_srst_done("R6 reset bit self-clears");
        chk(0, 3'd0, 16'h0009, 0, "R7 control after reset keeps disable");
        chk(0, 3'd1, 16'h0000, 0, "R7 timer cleared");
        chk(0, 3'd2, 16'h0000, 0, "R7 errcnt cleared");
        chk(0, 3'd3, 16'h0000, 0, "R7 errstat cleared");
        chk(0, 3'd4, 16'h0000, 0, "R7 imask cleared");
        chk(0, 3'd5, 16'h0000, 0, "R7 iflag cleared");
        chk(0, 3'd6, 16'h1234, 0, "R7 buscfg kept");
        chk(0, 3'd7, 16'hBEEF, 0, "R7 amask kept");
        repeat (20) @(posedge clk);
        chk(3, 3'd0, 16'd0, 0, "R8 protocol reset released");
        chk(0, 3'd1, 16'h0000, 0, "R10 timer holds while disabled");

        // enable; write 0 to reset bit
        wr(3'd0, 16'h0000);
        repeat (10) @(posedge clk);
        chk(0, 3'd0, 16'h0000, 0, "R6 zero write starts no reset");
        chk(2, 3'd0, 16'h0007, 0, "R1 enabled clocks on");
        chk(0, 3'd1, 16'h0000, 1, "R10 timer counts when running");

        // global soft reset
        wr(3'd4, 16'h00FF);
        @(negedge clk); glob_srst = 1'b1;
        @(negedge clk); glob_srst = 1'b0;
        chk(0, 3'd0, 16'h0010, 0, "R6 global request sets bit");
        wait_srst_done("R6 global reset completes");
        chk(0, 3'd4, 16'h0000, 0, "R7 imask cleared by global reset");
        chk(0, 3'd6, 16'h1234, 0, "R7 buscfg kept after global reset");

        repeat (20) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule